// File: doc/BRIEF.md
# Interrupt Controller Register Decoder

This block is the 32-bit memory-mapped front end of an interrupt controller. It takes one request per cycle, checks that it is a full, word-aligned access to a mapped offset, and returns a response one cycle later. Reads are answered from state that a neighbouring per-source storage block exposes. Writes become commands to that storage block.

The block holds only two registers of its own. The first is the domain interrupt-enable bit. The second is the last value written to the generate-message register.

Each accepted write raises a one-cycle `rescan` pulse. The delivery logic uses it to re-examine every source. Several registers read back something other than what a write to them does:

- Clear-pending words return the rectified input levels.
- Clear-enable words and all by-number registers read as zero.
- A big-endian set-pending alias byte-swaps the written number.

`NSRC` counts source slots including the unused slot 0. The bitmap arrays span `NW = ceil(NSRC/32)` words.

Top module: `intc_regdec`

## Requirements
- R1: Every request cycle (`req_valid`=1) is followed in the next cycle by `rsp_ready`=1 for exactly one cycle. After reset all outputs are 0.
- R2: A request with `req_addr[1:0]`≠0 or `req_bytes`≠4 gets `rsp_err`=1 and `rsp_rdata`=0. It has no side effect: no command, no `rescan` and no change to `dom_ie`.
- R3: Any offset outside the map gets `rsp_err`=1 with no side effect. The map is: 0x0000 domain; 0x0004+4(k-1) source-config for k in 1..NSRC-1; 0x1C00/0x1D00/0x1E00/0x1F00 + 4w, for w < NW, set-pending/clear-pending/set-enable/clear-enable; 0x1CDC/0x1DDC/0x1EDC/0x1FDC by-number; 0x2000 little-endian and 0x2004 big-endian set-pending by number; 0x3000 generate-message; 0x3004+4(k-1) target for k in 1..NSRC-1.
- R4: Only bit 8 of the domain register is writable, and it drives `dom_ie`. A read returns 0x8000_0004 | (`dom_ie`<<8).
- R5: A source-config write to source k emits command op 1 with index k and the data unchanged. A source-config read returns `cfg_rdata` while `rd_index`=k.
- R6: A target write to source k emits op 2 with index k and data & 0xFFFF_F7FF. The kept fields are hart index 31:18, guest index 17:12 and identity 10:0. A target read returns `tgt_rdata` while `rd_index`=k.
- R7: A write to bitmap word w emits index w and the written mask unchanged, so only its 1 bits act. The op is 3 for set-pending, 4 for clear-pending, 5 for set-enable and 6 for clear-enable.
- R8: Bit i of bitmap word w reflects source 32w+i. Set-pending words read `st_pending`, clear-pending words read `st_input`, and set-enable words read `st_enable`. Source 0 and sources ≥ NSRC read 0, and clear-enable words read 0.
- R9: By-number writes emit index = written value with op 7 (set-pending, including the little-endian alias), op 8 (clear-pending), op 9 (set-enable) or op 10 (clear-enable). A value of 0 or ≥ NSRC is accepted without a command. All by-number registers read 0.
- R10: A write to the big-endian alias byte-swaps the data before using it as the source number, then acts as op 7.
- R11: A generate-message write stores the data with bits 17:12 cleared, reads back as that value, and emits op 11 with that value and index 0.
- R12: `rescan` pulses in the response cycle of every accepted write and never for reads or rejected requests. `cmd_valid` implies `rescan`, and when `cmd_valid`=0 the `cmd_index` and `cmd_data` outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset within the block |
| req_bytes | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| st_pending | input | NSRC | Pending bit of each source |
| st_enable | input | NSRC | Enable bit of each source |
| st_input | input | NSRC | Rectified input level of each source |
| cfg_rdata | input | 32 | Source-config value of source `rd_index` |
| tgt_rdata | input | 32 | Target value of source `rd_index` |
| rd_index | output | IDXW | Source number decoded from `req_addr` for config and target reads |
| rsp_ready | output | 1 | Response valid |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data, 0 on error or write |
| cmd_valid | output | 1 | Command to the storage block |
| cmd_op | output | 4 | Command code (see R5–R11) |
| cmd_index | output | IDXW | Source number or bitmap word |
| cmd_data | output | 32 | Command data |
| rescan | output | 1 | Re-examine all sources for delivery |
| dom_ie | output | 1 | Domain interrupt enable |

## Verification
The bench targets the edges of each array. The last source-config and target words sit beside the first unmapped words, and the last bitmap word is only partly populated. A decoder with an off-by-one range would either answer those edge words or fail to reject the words just past them.

It writes by-number values of 0, NSRC-1 and NSRC. Issuing a command for an out-of-range number would corrupt a neighbouring slot. It also writes the big-endian alias with byte patterns that are valid only after the swap, so a missing swap targets the wrong source.

Writes of the wrong size to the domain register check that a rejected access cannot flip `dom_ie` or raise `rescan`. Reads of clear-pending words check that they return input levels and not pending bits.

// File: rtl/intc_regdec_pkg.sv
package intc_regdec_pkg;

    // Fixed offsets of the register map
    localparam int unsigned OFS_DOM      = 32'h0000;
    localparam int unsigned OFS_CFG      = 32'h0004;
    localparam int unsigned OFS_SETIP    = 32'h1C00;
    localparam int unsigned OFS_SETIPNUM = 32'h1CDC;
    localparam int unsigned OFS_CLRIP    = 32'h1D00;
    localparam int unsigned OFS_CLRIPNUM = 32'h1DDC;
    localparam int unsigned OFS_SETIE    = 32'h1E00;
    localparam int unsigned OFS_SETIENUM = 32'h1EDC;
    localparam int unsigned OFS_CLRIE    = 32'h1F00;
    localparam int unsigned OFS_CLRIENUM = 32'h1FDC;
    localparam int unsigned OFS_NUM_LE   = 32'h2000;
    localparam int unsigned OFS_NUM_BE   = 32'h2004;
    localparam int unsigned OFS_MSI      = 32'h3000;
    localparam int unsigned OFS_TGT      = 32'h3004;

    localparam logic [31:0] DOM_FIXED  = 32'h8000_0004;
    localparam int unsigned DOM_IE_BIT = 8;
    localparam logic [31:0] TGT_KEEP   = 32'hFFFF_F7FF;
    localparam logic [31:0] MSI_KEEP   = 32'hFFFC_0FFF;

    typedef enum logic [3:0] {
        RG_NONE, RG_DOM, RG_CFG, RG_SETIP, RG_SETIPNUM, RG_CLRIP, RG_CLRIPNUM,
        RG_SETIE, RG_SETIENUM, RG_CLRIE, RG_CLRIENUM, RG_NUM_LE, RG_NUM_BE,
        RG_MSI, RG_TGT
    } region_e;

    typedef enum logic [3:0] {
        OP_NONE       = 4'd0,
        OP_CFG_WR     = 4'd1,
        OP_TGT_WR     = 4'd2,
        OP_IP_SET_MSK = 4'd3,
        OP_IP_CLR_MSK = 4'd4,
        OP_IE_SET_MSK = 4'd5,
        OP_IE_CLR_MSK = 4'd6,
        OP_IP_SET_NUM = 4'd7,
        OP_IP_CLR_NUM = 4'd8,
        OP_IE_SET_NUM = 4'd9,
        OP_IE_CLR_NUM = 4'd10,
        OP_MSI_GEN    = 4'd11
    } cmd_op_e;

    function automatic logic [31:0] bswap32(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

endpackage

// File: rtl/intc_regdec_decode.sv
module intc_regdec_decode
    import intc_regdec_pkg::*;
#(
    parameter int unsigned NSRC = 48,
    parameter int unsigned AW   = 16,
    parameter int unsigned IDXW = 6
) (
    input  logic [AW-1:0]   addr,
    output region_e         rg,
    output logic [IDXW-1:0] idx
);
    localparam int unsigned NW      = (NSRC + 31) / 32;
    localparam int unsigned SRC_SPAN = (NSRC - 1) * 4;
    localparam int unsigned WORD_SPAN = NW * 4;

    int unsigned a;
    int unsigned rel;

    always_comb begin
        a   = 32'(addr);
        rg  = RG_NONE;
        rel = 0;
        if (a == OFS_DOM) begin
            rg = RG_DOM;
        end else if (a >= OFS_CFG && a < OFS_CFG + SRC_SPAN) begin
            rg = RG_CFG;  rel = (a >> 2);
        end else if (a >= OFS_SETIP && a < OFS_SETIP + WORD_SPAN) begin
            rg = RG_SETIP; rel = (a - OFS_SETIP) >> 2;
        end else if (a == OFS_SETIPNUM) begin
            rg = RG_SETIPNUM;
        end else if (a >= OFS_CLRIP && a < OFS_CLRIP + WORD_SPAN) begin
            rg = RG_CLRIP; rel = (a - OFS_CLRIP) >> 2;
        end else if (a == OFS_CLRIPNUM) begin
            rg = RG_CLRIPNUM;
        end else if (a >= OFS_SETIE && a < OFS_SETIE + WORD_SPAN) begin
            rg = RG_SETIE; rel = (a - OFS_SETIE) >> 2;
        end else if (a == OFS_SETIENUM) begin
            rg = RG_SETIENUM;
        end else if (a >= OFS_CLRIE && a < OFS_CLRIE + WORD_SPAN) begin
            rg = RG_CLRIE; rel = (a - OFS_CLRIE) >> 2;
        end else if (a == OFS_CLRIENUM) begin
            rg = RG_CLRIENUM;
        end else if (a == OFS_NUM_LE) begin
            rg = RG_NUM_LE;
        end else if (a == OFS_NUM_BE) begin
            rg = RG_NUM_BE;
        end else if (a == OFS_MSI) begin
            rg = RG_MSI;
        end else if (a >= OFS_TGT && a < OFS_TGT + SRC_SPAN) begin
            rg = RG_TGT;  rel = (a - OFS_MSI) >> 2;
        end
        idx = rel[IDXW-1:0];
    end
endmodule

// File: rtl/intc_regdec_rdmux.sv
module intc_regdec_rdmux
    import intc_regdec_pkg::*;
#(
    parameter int unsigned NSRC = 48,
    parameter int unsigned IDXW = 6
) (
    input  region_e         rg,
    input  logic [IDXW-1:0] idx,
    input  logic [NSRC-1:0] st_pending,
    input  logic [NSRC-1:0] st_enable,
    input  logic [NSRC-1:0] st_input,
    input  logic [31:0]     cfg_rdata,
    input  logic [31:0]     tgt_rdata,
    input  logic            ie,
    input  logic [31:0]     msi_val,
    output logic [31:0]     rdata
);
    localparam int unsigned NW   = (NSRC + 31) / 32;
    localparam int unsigned NBIT = NW * 32;

    logic [NBIT-1:0] pend_pad, en_pad, in_pad;

    // Source 0 and slots past the last source always read as zero
    for (genvar g = 0; g < NBIT; g++) begin : g_pad
        if (g >= 1 && g < NSRC) begin : g_live
            assign pend_pad[g] = st_pending[g];
            assign en_pad[g]   = st_enable[g];
            assign in_pad[g]   = st_input[g];
        end else begin : g_dead
            assign pend_pad[g] = 1'b0;
            assign en_pad[g]   = 1'b0;
            assign in_pad[g]   = 1'b0;
        end
    end

    always_comb begin
        unique case (rg)
            RG_DOM:   rdata = DOM_FIXED | (32'(ie) << DOM_IE_BIT);
            RG_CFG:   rdata = cfg_rdata;
            RG_TGT:   rdata = tgt_rdata;
            RG_SETIP: rdata = pend_pad[32*int'(idx) +: 32];
            RG_CLRIP: rdata = in_pad[32*int'(idx) +: 32];
            RG_SETIE: rdata = en_pad[32*int'(idx) +: 32];
            RG_MSI:   rdata = msi_val;
            default:  rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/intc_regdec.sv
module intc_regdec
    import intc_regdec_pkg::*;
#(
    parameter int unsigned NSRC = 48,
    parameter int unsigned AW   = 16,
    localparam int unsigned IDXW = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [2:0]      req_bytes,
    input  logic [31:0]     req_wdata,
    input  logic [NSRC-1:0] st_pending,
    input  logic [NSRC-1:0] st_enable,
    input  logic [NSRC-1:0] st_input,
    input  logic [31:0]     cfg_rdata,
    input  logic [31:0]     tgt_rdata,
    output logic [IDXW-1:0] rd_index,
    output logic            rsp_ready,
    output logic            rsp_err,
    output logic [31:0]     rsp_rdata,
    output logic            cmd_valid,
    output logic [3:0]      cmd_op,
    output logic [IDXW-1:0] cmd_index,
    output logic [31:0]     cmd_data,
    output logic            rescan,
    output logic            dom_ie
);
    region_e         rg;
    logic [IDXW-1:0] idx;
    logic [31:0]     rd_word;
    logic [31:0]     msi_q;
    logic            ie_q;
    cmd_op_e         op_n, op_q;
    logic [IDXW-1:0] cidx_n;
    logic [31:0]     cdata_n, num;
    logic            num_ok, acc_ok, wr_ok;

    intc_regdec_decode #(.NSRC(NSRC), .AW(AW), .IDXW(IDXW)) u_dec (
        .addr(req_addr), .rg(rg), .idx(idx)
    );

    intc_regdec_rdmux #(.NSRC(NSRC), .IDXW(IDXW)) u_rd (
        .rg(rg), .idx(idx), .st_pending(st_pending), .st_enable(st_enable),
        .st_input(st_input), .cfg_rdata(cfg_rdata), .tgt_rdata(tgt_rdata),
        .ie(ie_q), .msi_val(msi_q), .rdata(rd_word)
    );

    assign rd_index = idx;

    always_comb begin
        acc_ok  = (req_addr[1:0] == 2'b00) && (req_bytes == 3'd4) && (rg != RG_NONE);
        wr_ok   = req_valid && req_write && acc_ok;
        num     = (rg == RG_NUM_BE) ? bswap32(req_wdata) : req_wdata;
        num_ok  = (num != 32'h0) && (num < NSRC);
        op_n    = OP_NONE;
        cidx_n  = idx;
        cdata_n = req_wdata;
        unique case (rg)
            RG_CFG:      op_n = OP_CFG_WR;
            RG_TGT:      begin op_n = OP_TGT_WR; cdata_n = req_wdata & TGT_KEEP; end
            RG_SETIP:    op_n = OP_IP_SET_MSK;
            RG_CLRIP:    op_n = OP_IP_CLR_MSK;
            RG_SETIE:    op_n = OP_IE_SET_MSK;
            RG_CLRIE:    op_n = OP_IE_CLR_MSK;
            RG_SETIPNUM, RG_NUM_LE, RG_NUM_BE: op_n = num_ok ? OP_IP_SET_NUM : OP_NONE;
            RG_CLRIPNUM: op_n = num_ok ? OP_IP_CLR_NUM : OP_NONE;
            RG_SETIENUM: op_n = num_ok ? OP_IE_SET_NUM : OP_NONE;
            RG_CLRIENUM: op_n = num_ok ? OP_IE_CLR_NUM : OP_NONE;
            RG_MSI:      begin op_n = OP_MSI_GEN; cidx_n = '0; cdata_n = req_wdata & MSI_KEEP; end
            default:     op_n = OP_NONE;
        endcase
        if (rg inside {RG_SETIPNUM, RG_CLRIPNUM, RG_SETIENUM, RG_CLRIENUM, RG_NUM_LE, RG_NUM_BE}) begin
            cidx_n  = num[IDXW-1:0];
            cdata_n = 32'h0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_ready <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            cmd_valid <= 1'b0;
            op_q      <= OP_NONE;
            cmd_index <= '0;
            cmd_data  <= '0;
            rescan    <= 1'b0;
            ie_q      <= 1'b0;
            msi_q     <= '0;
        end else begin
            rsp_ready <= req_valid;
            rsp_err   <= req_valid && !acc_ok;
            rsp_rdata <= (req_valid && !req_write && acc_ok) ? rd_word : 32'h0;
            cmd_valid <= wr_ok && (op_n != OP_NONE);
            op_q      <= (wr_ok) ? op_n : OP_NONE;
            cmd_index <= (wr_ok && op_n != OP_NONE) ? cidx_n : '0;
            cmd_data  <= (wr_ok && op_n != OP_NONE) ? cdata_n : '0;
            rescan    <= wr_ok;
            if (wr_ok && rg == RG_DOM) ie_q  <= req_wdata[DOM_IE_BIT];
            if (wr_ok && rg == RG_MSI) msi_q <= req_wdata & MSI_KEEP;
        end
    end

    assign cmd_op = op_q;
    assign dom_ie = ie_q;

    // Assertions
    assert_ready_follows_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_ready);
    assert_ready_only_after_req_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_ready);
    assert_misaligned_err_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_addr[1:0] != 2'b00) |=> (rsp_err && rsp_rdata == 32'h0));
    assert_err_no_effect_R3: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (!cmd_valid && !rescan));
    assert_ie_held_R4: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write) |=> $stable(dom_ie));
    assert_tgt_fields_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 4'd2) |-> (cmd_data[11] == 1'b0));
    assert_cmd_has_rescan_R12: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (rescan && rsp_ready && !rsp_err));
    assert_read_no_rescan_R12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> !rescan);
endmodule

// File: tb/intc_regdec_test.sv
module intc_regdec_test;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 48;
    localparam int IW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [2:0]  req_bytes = 3'd4;
    logic [31:0] req_wdata = '0;
    logic [N-1:0] pend_v, en_v, in_v;
    logic [31:0] cfg_rdata, tgt_rdata;
    logic [IW-1:0] rd_index;
    logic rsp_ready, rsp_err, cmd_valid, rescan, dom_ie;
    logic [31:0] rsp_rdata, cmd_data;
    logic [3:0] cmd_op;
    logic [IW-1:0] cmd_index;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cfg_rdata = 32'hC000_0000 | {26'b0, rd_index};
    assign tgt_rdata = 32'hA000_0000 | {26'b0, rd_index};

    intc_regdec #(.NSRC(N), .AW(16)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_bytes(req_bytes), .req_wdata(req_wdata),
        .st_pending(pend_v), .st_enable(en_v), .st_input(in_v),
        .cfg_rdata(cfg_rdata), .tgt_rdata(tgt_rdata), .rd_index(rd_index),
        .rsp_ready(rsp_ready), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_index(cmd_index),
        .cmd_data(cmd_data), .rescan(rescan), .dom_ie(dom_ie)
    );

    // Reference model state
    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit m_ie = 0;
    logic [31:0] m_msi = 0;
    // pending (next-edge) and current expectations
    logic p_rdy, p_err, p_cv, p_rs; logic [31:0] p_rd, p_cd; int p_op, p_ci; string p_tag;
    logic e_rdy, e_err, e_cv, e_rs; logic [31:0] e_rd, e_cd; int e_op, e_ci; string e_tag;
    bit e_ie;

    task automatic set_idle();
        p_rdy = 0; p_err = 0; p_cv = 0; p_rs = 0; p_rd = 0; p_cd = 0; p_op = 0; p_ci = 0;
        p_tag = "R1";
    endtask

    function automatic logic [31:0] bits_of(input logic [N-1:0] v, input int w);
        logic [31:0] r = 0;
        for (int i = 0; i < 32; i++) begin
            int s = 32*w + i;
            if (s >= 1 && s < N) r[i] = v[s];
        end
        return r;
    endfunction

    task automatic model(input bit wr, input int a, input int bytes, input logic [31:0] wd, input string tag);
        int kind = 0, ix = 0; int num; bit err;
        if (a == 0) kind = 1;
        else if (a >= 4 && a < 4 + (N-1)*4) begin kind = 2; ix = a/4; end
        else if (a >= 'h1C00 && a < 'h1C08) begin kind = 3; ix = (a-'h1C00)/4; end
        else if (a >= 'h1D00 && a < 'h1D08) begin kind = 4; ix = (a-'h1D00)/4; end
        else if (a >= 'h1E00 && a < 'h1E08) begin kind = 5; ix = (a-'h1E00)/4; end
        else if (a >= 'h1F00 && a < 'h1F08) begin kind = 6; ix = (a-'h1F00)/4; end
        else if (a == 'h1CDC) kind = 7;
        else if (a == 'h1DDC) kind = 8;
        else if (a == 'h1EDC) kind = 9;
        else if (a == 'h1FDC) kind = 10;
        else if (a == 'h2000) kind = 11;
        else if (a == 'h2004) kind = 12;
        else if (a == 'h3000) kind = 13;
        else if (a >= 'h3004 && a < 'h3004 + (N-1)*4) begin kind = 14; ix = (a-'h3000)/4; end
        err = (a % 4 != 0) || (bytes != 4) || (kind == 0);
        set_idle();
        p_tag = tag; p_rdy = 1; p_err = err;
        if (err) return;
        if (!wr) begin
            case (kind)
                1: p_rd = 32'h8000_0004 | (m_ie ? 32'h100 : 0);
                2: p_rd = 32'hC000_0000 | ix;
                3: p_rd = bits_of(pend_v, ix);
                4: p_rd = bits_of(in_v, ix);
                5: p_rd = bits_of(en_v, ix);
                13: p_rd = m_msi;
                14: p_rd = 32'hA000_0000 | ix;
                default: p_rd = 0;
            endcase
            return;
        end
        p_rs = 1;
        case (kind)
            1: m_ie = wd[8];
            2: begin p_cv = 1; p_op = 1; p_ci = ix; p_cd = wd; end
            14: begin p_cv = 1; p_op = 2; p_ci = ix; p_cd = wd & 32'hFFFF_F7FF; end
            3, 4, 5, 6: begin p_cv = 1; p_op = kind; p_ci = ix; p_cd = wd; end
            7, 8, 9, 10, 11, 12: begin
                num = (kind == 12) ? {wd[7:0], wd[15:8], wd[23:16], wd[31:24]} : wd;
                if (num > 0 && num < N) begin
                    p_cv = 1; p_ci = num;
                    p_op = (kind == 8) ? 8 : (kind == 9) ? 9 : (kind == 10) ? 10 : 7;
                end
            end
            13: begin m_msi = wd & 32'hFFFC_0FFF; p_cv = 1; p_op = 11; p_ci = 0; p_cd = m_msi; end
            default: ;
        endcase
    endtask

    always @(posedge clk) begin
        e_rdy <= p_rdy; e_err <= p_err; e_rd <= p_rd; e_cv <= p_cv; e_op <= p_op;
        e_ci <= p_ci; e_cd <= p_cd; e_rs <= p_rs; e_tag <= p_tag; e_ie <= m_ie;
        cycles <= cycles + 1;
    end

    task automatic chk(input string sig, input logic [31:0] got, input logic [31:0] exp, inout bit bad);
        if (got !== exp) begin
            $display("FAIL %s %s got=%h exp=%h at %0t", e_tag, sig, got, exp, $time);
            bad = 1;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && cycles > 1) begin
            bit bad = 0;
            chk("rsp_ready", 32'(rsp_ready), 32'(e_rdy), bad);
            chk("rsp_err",   32'(rsp_err),   32'(e_err), bad);
            chk("rsp_rdata", rsp_rdata,      e_rd,       bad);
            chk("cmd_valid", 32'(cmd_valid), 32'(e_cv),  bad);
            chk("cmd_op",    32'(cmd_op),    32'(e_op),  bad);
            chk("cmd_index", 32'(cmd_index), 32'(e_ci),  bad);
            chk("cmd_data",  cmd_data,       e_cd,       bad);
            chk("rescan",    32'(rescan),    32'(e_rs),  bad);
            chk("dom_ie",    32'(dom_ie),    32'(e_ie),  bad);
            n_cmp++;
            if (bad) n_bad++;
        end
    end

    task automatic access(input bit wr, input int a, input int bytes, input logic [31:0] wd, input string tag);
        @(negedge clk); #1;
        req_valid = 1; req_write = wr; req_addr = a[15:0]; req_bytes = bytes[2:0]; req_wdata = wd;
        model(wr, a, bytes, wd, tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            req_valid = 0; req_write = 0;
            set_idle();
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        $display("FAIL watchdog expired");
        n_bad++;
        finish_run();
    end

    initial begin
        pend_v = 48'hA5A5_1234_F00F;
        en_v   = 48'h0F0F_8001_FFFF;
        in_v   = 48'hFFFF_0000_5555;
        set_idle();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        idle(2);                                           // R1 reset state
        // R4 domain register
        access(0, 'h0000, 4, 0, "R4");
        access(1, 'h0000, 4, 32'hFFFF_FFFF, "R4");
        access(0, 'h0000, 4, 0, "R4");
        // R2 bad size / misaligned: no effect on dom_ie
        access(1, 'h0000, 2, 32'h0, "R2");
        access(1, 'h0000, 1, 32'h0, "R2");
        access(0, 'h0002, 4, 0, "R2");
        access(1, 'h3006, 4, 32'hFFFF_FFFF, "R2");
        access(0, 'h0000, 4, 0, "R2");
        access(1, 'h0000, 4, 32'hFFFF_FEFF, "R4");
        access(0, 'h0000, 4, 0, "R4");
        idle(1);
        // R3 unmapped
        access(0, 'h00C0, 4, 0, "R3");
        access(1, 'h1C08, 4, 32'h1, "R3");
        access(0, 'h1000, 4, 0, "R3");
        access(1, 'h30C0, 4, 32'h1, "R3");
        access(0, 'h2008, 4, 0, "R3");
        // R5 source config
        access(1, 'h0008, 4, 32'h0000_0405, "R5");
        access(0, 'h0004, 4, 0, "R5");
        access(0, 'h00BC, 4, 0, "R5");
        // R6 target
        access(1, 'h3008, 4, 32'hFFFF_FFFF, "R6");
        access(1, 'h30BC, 4, 32'h0004_1823, "R6");
        access(0, 'h3004, 4, 0, "R6");
        access(0, 'h30BC, 4, 0, "R6");
        // R7 bitmap writes
        access(1, 'h1C00, 4, 32'h8000_0003, "R7");
        access(1, 'h1D04, 4, 32'h0000_0000, "R7");
        access(1, 'h1E04, 4, 32'h0000_FFFF, "R7");
        access(1, 'h1F00, 4, 32'h1234_5678, "R7");
        // R8 bitmap reads
        access(0, 'h1C00, 4, 0, "R8");
        access(0, 'h1C04, 4, 0, "R8");
        access(0, 'h1D00, 4, 0, "R8");
        access(0, 'h1D04, 4, 0, "R8");
        access(0, 'h1E00, 4, 0, "R8");
        access(0, 'h1E04, 4, 0, "R8");
        access(0, 'h1F00, 4, 0, "R8");
        idle(1);
        pend_v = 48'hFFFF_FFFF_FFFF; in_v = 48'h0; en_v = 48'h8000_0000_0001;
        access(0, 'h1C00, 4, 0, "R8");
        access(0, 'h1C04, 4, 0, "R8");
        access(0, 'h1D00, 4, 0, "R8");
        access(0, 'h1E00, 4, 0, "R8");
        access(0, 'h1E04, 4, 0, "R8");
        // R9 by-number
        access(1, 'h1CDC, 4, 32'd5, "R9");
        access(1, 'h1DDC, 4, 32'd47, "R9");
        access(1, 'h1EDC, 4, 32'd1, "R9");
        access(1, 'h1FDC, 4, 32'd33, "R9");
        access(1, 'h2000, 4, 32'd12, "R9");
        access(1, 'h1CDC, 4, 32'd0, "R9");
        access(1, 'h1EDC, 4, 32'd48, "R9");
        access(1, 'h2000, 4, 32'h0100_0000, "R9");
        access(0, 'h1CDC, 4, 0, "R9");
        access(0, 'h1FDC, 4, 0, "R9");
        access(0, 'h2000, 4, 0, "R9");
        access(0, 'h2004, 4, 0, "R9");
        // R10 big-endian alias
        access(1, 'h2004, 4, 32'h0500_0000, "R10");
        access(1, 'h2004, 4, 32'h2F00_0000, "R10");
        access(1, 'h2004, 4, 32'h0000_0005, "R10");
        // R11 generate message
        access(1, 'h3000, 4, 32'hFFFF_FFFF, "R11");
        access(0, 'h3000, 4, 0, "R11");
        access(1, 'h3000, 4, 32'h0004_5025, "R11");
        access(0, 'h3000, 4, 0, "R11");
        // R12 rescan on writes only, back-to-back mix
        access(1, 'h0000, 4, 32'h0, "R12");
        access(0, 'h0008, 4, 0, "R12");
        access(1, 'h1C00, 2, 32'hFFFF, "R12");
        access(1, 'h1E00, 4, 32'h0, "R12");
        idle(3);
        finish_run();
    end
endmodule